// File: doc/BRIEF.md
# Sound Command Mailbox

This block couples a 16-bit host processor bus to an 8-bit audio processor bus so the two can trade command and reply bytes. It keeps two downstream command bytes (host to audio) and two upstream reply bytes (audio to host). Two pending flags track the primary command and the primary reply. Each flag is set by a write on one side and cleared by a read on the other.

A primary command write sends a one-cycle non-maskable pulse to the audio processor. The same write raises a trigger level for counter channel 2. A primary reply write raises a level interrupt toward the host, which holds until the host acknowledges it. Both sides can read a status byte carrying the two flags and a 3-bit coin field. On the host side only the upper byte lane carries data.

On the audio side, selects are decoded through a fixed address mask. Two tone-generator chips are reached through decoded select strobes. One further select fires a one-cycle counter channel 0 trigger.

Top module: `snd_mbx`

## Requirements
- R1: After reset, `snd_nmi`, `main_irq`, `ctc_trg0`, `ctc_trg2` and both pending flags are 0. `led` and all four mailbox bytes are 0x00.
- R2: A host write to register 1 with `m_ube` high does three things. It loads `m_wdata[15:8]` into the primary command byte and sets the command flag (status bit 7, also driven on `ctc_trg2`). It also drives `snd_nmi` high for exactly the one cycle after the write.
- R3: An audio read whose masked select (address AND 0x61) equals 0x41 returns the primary command byte and clears the command flag. If a host register 1 write happens in the same cycle, the flag stays set.
- R4: An audio write to masked select 0x41 loads the primary reply byte, sets the reply flag (status bit 6) and raises `main_irq`. `main_irq` stays high until a cycle with `main_irq_ack` high; a reply write in that same cycle keeps it high.
- R5: A host read of register 1 returns {reply byte, 0x00} and clears the reply flag. It leaves `main_irq` unchanged.
- R6: A host read of register 2 returns {cmd_flag, reply_flag, 0, 0, 1, coin[2:0]} in bits 15:8 and 0x00 in bits 7:0.
- R7: An audio read of masked select 0x00 returns {cmd_flag, reply_flag, 0, 0, v, coin[2:0]}, where v is 1 exactly when `coin` is not 3'b111.
- R8: Three paths carry the secondary bytes and the lamp byte:
  - a host write to register 0 loads the secondary command byte, which an audio read of select 0x40 returns;
  - an audio write to select 0x40 loads the secondary reply byte, which a host read of register 0 returns in bits 15:8;
  - a host write to register 2 loads `led`.
- R9: Host writes with `m_ube` low change no byte, flag, `led` or `snd_nmi`.
- R10: Host reads of registers 3 to 15 return 0xFF00.
- R11: Audio address bits outside mask 0x61 are ignored. Audio reads of masked selects 0x20, 0x60 and 0x61 return 0x00.
- R12: For chip g (0 or 1), masked select g*0x20 is the control port and g*0x20+1 the data port:
  - a write to the control port pulses `psg_ctl_wr[g]`;
  - a write to the data port pulses `psg_dat_wr[g]`;
  - a read of the data port pulses `psg_dat_rd[g]` and returns `psg_rdata[8g+7:8g]`.

  All of these strobes are combinational, in the access cycle.
- R13: An audio write to masked select 0x61 drives `ctc_trg0` high for exactly the one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both buses |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_addr | input | 4 | Host register select |
| m_wdata | input | 16 | Host write data; only bits 15:8 are used |
| m_wr | input | 1 | Host write strobe |
| m_rd | input | 1 | Host read strobe (gates read side effects) |
| m_ube | input | 1 | Host upper byte lane enable |
| m_rdata | output | 16 | Host read data |
| s_addr | input | 8 | Audio select address |
| s_wdata | input | 8 | Audio write data |
| s_wr | input | 1 | Audio write strobe |
| s_rd | input | 1 | Audio read strobe |
| s_rdata | output | 8 | Audio read data |
| coin | input | 3 | Coin input field |
| psg_rdata | input | 16 | Read data from the two tone chips, chip g in bits 8g+7:8g |
| psg_ctl_wr | output | 2 | Tone chip control-port write strobes |
| psg_dat_wr | output | 2 | Tone chip data-port write strobes |
| psg_dat_rd | output | 2 | Tone chip data-port read strobes |
| main_irq_ack | input | 1 | Host interrupt acknowledge |
| snd_nmi | output | 1 | One-cycle non-maskable pulse to the audio processor |
| main_irq | output | 1 | Level interrupt to the host |
| ctc_trg0 | output | 1 | Counter channel 0 trigger pulse |
| ctc_trg2 | output | 1 | Counter channel 2 trigger level |
| led | output | 8 | Lamp byte from host register 2 |

## Verification
The assertions watch the strobes and the interrupt outputs on every cycle:
- the NMI pulse and the channel 0 pulse each follow their write one cycle later and have no other cause;
- the host interrupt rises only on a reply write and holds until acknowledged;
- the channel 2 level drops after an uncontested command read;
- at most one tone-chip write strobe is active at a time.

Only the bench scenarios can show that the data bytes travel end to end, that the coin valid bit and the flags appear in the two status formats, and that mirrored audio addresses alias correctly. The same goes for ignored lane-less writes and the set-wins collisions.

// File: rtl/snd_mbx_pkg.sv
package snd_mbx_pkg;

  localparam int LANE_W = 8;
  localparam int COIN_W = 3;

  // host register map (low address bits)
  localparam int MREG_CMD_AUX = 0;
  localparam int MREG_CMD     = 1;
  localparam int MREG_STATUS  = 2;

  // audio select map, applied after masking
  localparam logic [7:0] SSEL_MASK   = 8'h61;
  localparam logic [7:0] SSEL_STATUS = 8'h00;
  localparam logic [7:0] SSEL_AUX    = 8'h40;
  localparam logic [7:0] SSEL_CMD    = 8'h41;
  localparam logic [7:0] SSEL_TRG0   = 8'h61;
  localparam int         PSG_STRIDE  = 32;

  typedef enum logic [1:0] {
    MRD_REP_AUX,
    MRD_REP,
    MRD_STATUS,
    MRD_NONE
  } mrd_sel_t;

  typedef enum logic [2:0] {
    SRD_STATUS,
    SRD_PSG,
    SRD_AUX,
    SRD_CMD,
    SRD_NONE
  } srd_sel_t;

  typedef struct packed {
    logic     wr_aux;
    logic     wr_cmd;
    logic     wr_led;
    logic     rd_rep;
    mrd_sel_t rsel;
  } mdec_t;

  typedef struct packed {
    logic     wr_aux;
    logic     wr_rep;
    logic     wr_trg0;
    logic     rd_cmd;
    srd_sel_t rsel;
  } sdec_t;

endpackage

// File: rtl/snd_mbx_main_dec.sv
module snd_mbx_main_dec
  import snd_mbx_pkg::*;
#(
  parameter int MADDR_W = 4
) (
  input  logic [MADDR_W-1:0] addr,
  input  logic               wr,
  input  logic               rd,
  input  logic               ube,
  output mdec_t              dec
);

  localparam logic [MADDR_W-1:0] A_AUX = MADDR_W'(MREG_CMD_AUX);
  localparam logic [MADDR_W-1:0] A_CMD = MADDR_W'(MREG_CMD);
  localparam logic [MADDR_W-1:0] A_STS = MADDR_W'(MREG_STATUS);

  logic lane_wr;

  always_comb begin
    lane_wr    = wr & ube;
    dec.wr_aux = lane_wr && (addr == A_AUX);
    dec.wr_cmd = lane_wr && (addr == A_CMD);
    dec.wr_led = lane_wr && (addr == A_STS);
    dec.rd_rep = rd && (addr == A_CMD);
    if (addr == A_AUX)      dec.rsel = MRD_REP_AUX;
    else if (addr == A_CMD) dec.rsel = MRD_REP;
    else if (addr == A_STS) dec.rsel = MRD_STATUS;
    else                    dec.rsel = MRD_NONE;
  end

endmodule

// File: rtl/snd_mbx_snd_dec.sv
module snd_mbx_snd_dec
  import snd_mbx_pkg::*;
#(
  parameter int SADDR_W = 8,
  parameter int NUM_PSG = 2
) (
  input  logic [SADDR_W-1:0] addr,
  input  logic               wr,
  input  logic               rd,
  output sdec_t              dec,
  output logic [NUM_PSG-1:0] psg_ctl_wr,
  output logic [NUM_PSG-1:0] psg_dat_wr,
  output logic [NUM_PSG-1:0] psg_dat_rd,
  output logic [NUM_PSG-1:0] psg_hit
);

  localparam logic [SADDR_W-1:0] MASK  = SADDR_W'(SSEL_MASK);
  localparam logic [SADDR_W-1:0] S_STS = SADDR_W'(SSEL_STATUS);
  localparam logic [SADDR_W-1:0] S_AUX = SADDR_W'(SSEL_AUX);
  localparam logic [SADDR_W-1:0] S_CMD = SADDR_W'(SSEL_CMD);
  localparam logic [SADDR_W-1:0] S_TRG = SADDR_W'(SSEL_TRG0);

  logic [SADDR_W-1:0] sel;
  assign sel = addr & MASK;

  for (genvar g = 0; g < NUM_PSG; g++) begin : g_psg
    localparam logic [SADDR_W-1:0] CTL_A = SADDR_W'(g * PSG_STRIDE);
    localparam logic [SADDR_W-1:0] DAT_A = SADDR_W'(g * PSG_STRIDE + 1);
    assign psg_ctl_wr[g] = wr && (sel == CTL_A);
    assign psg_dat_wr[g] = wr && (sel == DAT_A);
    assign psg_hit[g]    = (sel == DAT_A);
    assign psg_dat_rd[g] = rd && (sel == DAT_A);
  end

  always_comb begin
    dec.wr_aux  = wr && (sel == S_AUX);
    dec.wr_rep  = wr && (sel == S_CMD);
    dec.wr_trg0 = wr && (sel == S_TRG);
    dec.rd_cmd  = rd && (sel == S_CMD);
    if (sel == S_STS)      dec.rsel = SRD_STATUS;
    else if (|psg_hit)     dec.rsel = SRD_PSG;
    else if (sel == S_AUX) dec.rsel = SRD_AUX;
    else if (sel == S_CMD) dec.rsel = SRD_CMD;
    else                   dec.rsel = SRD_NONE;
  end

endmodule

// File: rtl/snd_mbx_ctl.sv
module snd_mbx_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_wr,
  input  logic cmd_rd,
  input  logic rep_wr,
  input  logic rep_rd,
  input  logic irq_ack,
  input  logic trg0_wr,
  output logic cmd_pend,
  output logic rep_pend,
  output logic main_irq,
  output logic snd_nmi,
  output logic ctc_trg0
);

  logic cmd_pend_d, rep_pend_d, main_irq_d, snd_nmi_d, ctc_trg0_d;

  // set wins over clear on every flag
  always_comb begin
    cmd_pend_d = cmd_wr | (cmd_pend & ~cmd_rd);
    rep_pend_d = rep_wr | (rep_pend & ~rep_rd);
    main_irq_d = rep_wr | (main_irq & ~irq_ack);
    snd_nmi_d  = cmd_wr;
    ctc_trg0_d = trg0_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_pend <= 1'b0;
      rep_pend <= 1'b0;
      main_irq <= 1'b0;
      snd_nmi  <= 1'b0;
      ctc_trg0 <= 1'b0;
    end else begin
      cmd_pend <= cmd_pend_d;
      rep_pend <= rep_pend_d;
      main_irq <= main_irq_d;
      snd_nmi  <= snd_nmi_d;
      ctc_trg0 <= ctc_trg0_d;
    end
  end

endmodule

// File: rtl/snd_mbx.sv
module snd_mbx
  import snd_mbx_pkg::*;
#(
  parameter int MADDR_W = 4,
  parameter int MDATA_W = 16,
  parameter int SADDR_W = 8,
  parameter int NUM_PSG = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [MADDR_W-1:0]        m_addr,
  input  logic [MDATA_W-1:0]        m_wdata,
  input  logic                      m_wr,
  input  logic                      m_rd,
  input  logic                      m_ube,
  output logic [MDATA_W-1:0]        m_rdata,
  input  logic [SADDR_W-1:0]        s_addr,
  input  logic [LANE_W-1:0]         s_wdata,
  input  logic                      s_wr,
  input  logic                      s_rd,
  output logic [LANE_W-1:0]         s_rdata,
  input  logic [COIN_W-1:0]         coin,
  input  logic [NUM_PSG*LANE_W-1:0] psg_rdata,
  output logic [NUM_PSG-1:0]        psg_ctl_wr,
  output logic [NUM_PSG-1:0]        psg_dat_wr,
  output logic [NUM_PSG-1:0]        psg_dat_rd,
  input  logic                      main_irq_ack,
  output logic                      snd_nmi,
  output logic                      main_irq,
  output logic                      ctc_trg0,
  output logic                      ctc_trg2,
  output logic [LANE_W-1:0]         led
);

  localparam int LOW_W = MDATA_W - LANE_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // decode
  mdec_t mdec;
  sdec_t sdec;
  logic [NUM_PSG-1:0] psg_hit;

  snd_mbx_main_dec #(.MADDR_W(MADDR_W)) main_dec_i (
    .addr (m_addr),
    .wr   (m_wr),
    .rd   (m_rd),
    .ube  (m_ube),
    .dec  (mdec)
  );

  snd_mbx_snd_dec #(.SADDR_W(SADDR_W), .NUM_PSG(NUM_PSG)) snd_dec_i (
    .addr       (s_addr),
    .wr         (s_wr),
    .rd         (s_rd),
    .dec        (sdec),
    .psg_ctl_wr (psg_ctl_wr),
    .psg_dat_wr (psg_dat_wr),
    .psg_dat_rd (psg_dat_rd),
    .psg_hit    (psg_hit)
  );

  // handshake flags and strobes
  logic cmd_pend, rep_pend;

  snd_mbx_ctl ctl_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cmd_wr   (mdec.wr_cmd),
    .cmd_rd   (sdec.rd_cmd),
    .rep_wr   (sdec.wr_rep),
    .rep_rd   (mdec.rd_rep),
    .irq_ack  (main_irq_ack),
    .trg0_wr  (sdec.wr_trg0),
    .cmd_pend (cmd_pend),
    .rep_pend (rep_pend),
    .main_irq (main_irq),
    .snd_nmi  (snd_nmi),
    .ctc_trg0 (ctc_trg0)
  );

  assign ctc_trg2 = cmd_pend;

  // mailbox bytes
  logic [LANE_W-1:0] m_byte;
  logic [LANE_W-1:0] cmd_q, aux_q, rep_q, rep_aux_q, led_q;
  logic [LANE_W-1:0] cmd_d, aux_d, rep_d, rep_aux_d, led_d;
  logic              unused_low;

  assign m_byte     = m_wdata[MDATA_W-1 -: LANE_W];
  assign unused_low = ^m_wdata[LOW_W-1:0] ^ m_rd;

  always_comb begin
    cmd_d     = mdec.wr_cmd ? m_byte  : cmd_q;
    aux_d     = mdec.wr_aux ? m_byte  : aux_q;
    led_d     = mdec.wr_led ? m_byte  : led_q;
    rep_d     = sdec.wr_rep ? s_wdata : rep_q;
    rep_aux_d = sdec.wr_aux ? s_wdata : rep_aux_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cmd_q     <= '0;
      aux_q     <= '0;
      led_q     <= '0;
      rep_q     <= '0;
      rep_aux_q <= '0;
    end else begin
      cmd_q     <= cmd_d;
      aux_q     <= aux_d;
      led_q     <= led_d;
      rep_q     <= rep_d;
      rep_aux_q <= rep_aux_d;
    end
  end

  assign led = led_q;

  // status bytes
  logic [LANE_W-1:0] m_status, s_status;
  logic              coin_any;

  always_comb begin
    coin_any = ~&coin;
    m_status = {cmd_pend, rep_pend, 2'b00, 1'b1, coin};
    s_status = {cmd_pend, rep_pend, 2'b00, coin_any, coin};
  end

  // read data
  logic [LANE_W-1:0] m_rbyte, psg_rbyte;

  always_comb begin
    case (mdec.rsel)
      MRD_REP_AUX: m_rbyte = rep_aux_q;
      MRD_REP:     m_rbyte = rep_q;
      MRD_STATUS:  m_rbyte = m_status;
      default:     m_rbyte = '1;
    endcase
    m_rdata = {m_rbyte, {LOW_W{1'b0}}};
  end

  always_comb begin
    psg_rbyte = '0;
    for (int g = 0; g < NUM_PSG; g++) begin
      psg_rbyte = psg_rbyte | (psg_rdata[g*LANE_W +: LANE_W] & {LANE_W{psg_hit[g]}});
    end
    case (sdec.rsel)
      SRD_STATUS: s_rdata = s_status;
      SRD_PSG:    s_rdata = psg_rbyte;
      SRD_AUX:    s_rdata = aux_q;
      SRD_CMD:    s_rdata = cmd_q;
      default:    s_rdata = '0;
    endcase
  end

endmodule

// File: rtl/snd_mbx_chk.sv
module snd_mbx_chk #(
  parameter int MADDR_W = 4,
  parameter int SADDR_W = 8,
  parameter int NUM_PSG = 2
) (
  input logic               clk,
  input logic               rst_ok,
  input logic [MADDR_W-1:0] m_addr,
  input logic               m_wr,
  input logic               m_ube,
  input logic [SADDR_W-1:0] s_addr,
  input logic               s_wr,
  input logic               s_rd,
  input logic               main_irq_ack,
  input logic               snd_nmi,
  input logic               main_irq,
  input logic               ctc_trg0,
  input logic               ctc_trg2,
  input logic [NUM_PSG-1:0] psg_ctl_wr,
  input logic [NUM_PSG-1:0] psg_dat_wr
);

  logic [SADDR_W-1:0] ssel;
  logic               host_cmd, snd_cmd_rd, snd_rep_wr, snd_trg;

  assign ssel       = s_addr & SADDR_W'(8'h61);
  assign host_cmd   = m_wr && m_ube && (m_addr == MADDR_W'(1));
  assign snd_cmd_rd = s_rd && (ssel == SADDR_W'(8'h41));
  assign snd_rep_wr = s_wr && (ssel == SADDR_W'(8'h41));
  assign snd_trg    = s_wr && (ssel == SADDR_W'(8'h61));

  a_r2_nmi_follows: assert property (@(posedge clk) disable iff (!rst_ok)
    host_cmd |=> snd_nmi);

  a_r9_nmi_cause: assert property (@(posedge clk) disable iff (!rst_ok)
    snd_nmi |-> $past(host_cmd));

  a_r3_trg2_drop: assert property (@(posedge clk) disable iff (!rst_ok)
    (snd_cmd_rd && !host_cmd) |=> !ctc_trg2);

  a_r2_trg2_raise: assert property (@(posedge clk) disable iff (!rst_ok)
    host_cmd |=> ctc_trg2);

  a_r4_irq_set: assert property (@(posedge clk) disable iff (!rst_ok)
    snd_rep_wr |=> main_irq);

  a_r4_irq_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    (main_irq && !main_irq_ack) |=> main_irq);

  a_r4_irq_cause: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(main_irq) |-> $past(snd_rep_wr));

  a_r13_trg0_follows: assert property (@(posedge clk) disable iff (!rst_ok)
    snd_trg |=> ctc_trg0);

  a_r13_trg0_cause: assert property (@(posedge clk) disable iff (!rst_ok)
    ctc_trg0 |-> $past(snd_trg));

  a_r12_psg_excl: assert property (@(posedge clk) disable iff (!rst_ok)
    $onehot0({psg_ctl_wr, psg_dat_wr}));

endmodule

bind snd_mbx snd_mbx_chk #(
  .MADDR_W (MADDR_W),
  .SADDR_W (SADDR_W),
  .NUM_PSG (NUM_PSG)
) chk_i (
  .clk          (clk),
  .rst_ok       (rst_sync_n),
  .m_addr       (m_addr),
  .m_wr         (m_wr),
  .m_ube        (m_ube),
  .s_addr       (s_addr),
  .s_wr         (s_wr),
  .s_rd         (s_rd),
  .main_irq_ack (main_irq_ack),
  .snd_nmi      (snd_nmi),
  .main_irq     (main_irq),
  .ctc_trg0     (ctc_trg0),
  .ctc_trg2     (ctc_trg2),
  .psg_ctl_wr   (psg_ctl_wr),
  .psg_dat_wr   (psg_dat_wr)
);

// File: tb/snd_mbx_tb_top.sv
module snd_mbx_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NPSG       = 2;

  logic        clk;
  logic        rst_n;
  logic [3:0]  m_addr;
  logic [15:0] m_wdata;
  logic        m_wr, m_rd, m_ube;
  logic [15:0] m_rdata;
  logic [7:0]  s_addr, s_wdata, s_rdata;
  logic        s_wr, s_rd;
  logic [2:0]  coin;
  logic [15:0] psg_rdata;
  logic [1:0]  psg_ctl_wr, psg_dat_wr, psg_dat_rd;
  logic        main_irq_ack, snd_nmi, main_irq, ctc_trg0, ctc_trg2;
  logic [7:0]  led;

  snd_mbx dut_i (
    .clk(clk), .rst_n(rst_n),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_wr(m_wr), .m_rd(m_rd), .m_ube(m_ube),
    .m_rdata(m_rdata),
    .s_addr(s_addr), .s_wdata(s_wdata), .s_wr(s_wr), .s_rd(s_rd), .s_rdata(s_rdata),
    .coin(coin), .psg_rdata(psg_rdata),
    .psg_ctl_wr(psg_ctl_wr), .psg_dat_wr(psg_dat_wr), .psg_dat_rd(psg_dat_rd),
    .main_irq_ack(main_irq_ack), .snd_nmi(snd_nmi), .main_irq(main_irq),
    .ctc_trg0(ctc_trg0), .ctc_trg2(ctc_trg2), .led(led)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int  n_cmp = 0;
  int  n_err = 0;
  bit  done  = 0;

  // reference model
  logic [7:0] md_cmd, md_aux, md_rep, md_rep_aux, md_led;
  logic       md_cp, md_rp, md_irq;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ssel_of(input logic [7:0] a);
    return a & 8'h61;
  endfunction

  function automatic logic [15:0] exp_mread(input logic [3:0] a);
    case (a)
      4'd0:    return {md_rep_aux, 8'h00};
      4'd1:    return {md_rep, 8'h00};
      4'd2:    return {md_cp, md_rp, 2'b00, 1'b1, coin, 8'h00};
      default: return 16'hFF00;
    endcase
  endfunction

  function automatic logic [7:0] exp_sread(input logic [7:0] a);
    case (ssel_of(a))
      8'h00:   return {md_cp, md_rp, 2'b00, (coin != 3'b111), coin};
      8'h01:   return psg_rdata[7:0];
      8'h21:   return psg_rdata[15:8];
      8'h40:   return md_aux;
      8'h41:   return md_cmd;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string mreq(input logic [3:0] a);
    return (a == 4'd1) ? "R5" : (a == 4'd2) ? "R6" : (a == 4'd0) ? "R8" : "R10";
  endfunction

  function automatic string sreq(input logic [7:0] a);
    case (ssel_of(a))
      8'h00:        return "R7";
      8'h01, 8'h21: return "R12";
      8'h40:        return "R8";
      8'h41:        return "R3";
      default:      return "R11";
    endcase
  endfunction

  task automatic idle_inputs();
    m_wr = 0; m_rd = 0; m_ube = 0; s_wr = 0; s_rd = 0; main_irq_ack = 0;
  endtask

  task automatic mw(input logic [3:0] a, input logic [15:0] d, input bit ube);
    m_addr = a; m_wdata = d; m_ube = ube; m_wr = 1;
    @(posedge clk); @(negedge clk);
    idle_inputs();
    if (ube) begin
      if (a == 4'd0) md_aux = d[15:8];
      if (a == 4'd1) begin md_cmd = d[15:8]; md_cp = 1; end
      if (a == 4'd2) md_led = d[15:8];
    end
    check(ube ? "R2" : "R9", {15'd0, snd_nmi}, {15'd0, (ube && a == 4'd1)});
    check("R2", {15'd0, ctc_trg2}, {15'd0, md_cp});
    check(ube ? "R8" : "R9", {8'd0, led}, {8'd0, md_led});
    @(negedge clk);
    check("R2", {15'd0, snd_nmi}, 16'd0);
  endtask

  task automatic mr(input logic [3:0] a);
    m_addr = a; m_rd = 1;
    #1 check(mreq(a), m_rdata, exp_mread(a));
    @(posedge clk); @(negedge clk);
    idle_inputs();
    if (a == 4'd1) md_rp = 0;
    check("R5", {15'd0, main_irq}, {15'd0, md_irq});
  endtask

  task automatic sw(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] s;
    s = ssel_of(a);
    s_addr = a; s_wdata = d; s_wr = 1;
    #1;
    for (int g = 0; g < NPSG; g++) begin
      check("R12", {15'd0, psg_ctl_wr[g]}, {15'd0, (s == 8'(g * 32))});
      check("R12", {15'd0, psg_dat_wr[g]}, {15'd0, (s == 8'(g * 32 + 1))});
    end
    @(posedge clk); @(negedge clk);
    idle_inputs();
    if (s == 8'h40) md_rep_aux = d;
    if (s == 8'h41) begin md_rep = d; md_rp = 1; md_irq = 1; end
    check("R13", {15'd0, ctc_trg0}, {15'd0, (s == 8'h61)});
    check("R4", {15'd0, main_irq}, {15'd0, md_irq});
    @(negedge clk);
    check("R13", {15'd0, ctc_trg0}, 16'd0);
  endtask

  task automatic sr(input logic [7:0] a);
    logic [7:0] s;
    s = ssel_of(a);
    s_addr = a; s_rd = 1;
    #1 check(sreq(a), {8'd0, s_rdata}, {8'd0, exp_sread(a)});
    for (int g = 0; g < NPSG; g++)
      check("R12", {15'd0, psg_dat_rd[g]}, {15'd0, (s == 8'(g * 32 + 1))});
    @(posedge clk); @(negedge clk);
    idle_inputs();
    if (s == 8'h41) md_cp = 0;
    check("R3", {15'd0, ctc_trg2}, {15'd0, md_cp});
  endtask

  task automatic ack();
    main_irq_ack = 1;
    @(posedge clk); @(negedge clk);
    idle_inputs();
    md_irq = 0;
    check("R4", {15'd0, main_irq}, 16'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle_inputs();
    rst_n = 0; m_addr = 0; m_wdata = 0; s_addr = 0; s_wdata = 0;
    coin = 3'b111; psg_rdata = 16'hB25A;
    md_cmd = 0; md_aux = 0; md_rep = 0; md_rep_aux = 0; md_led = 0;
    md_cp = 0; md_rp = 0; md_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1", {12'd0, snd_nmi, main_irq, ctc_trg0, ctc_trg2}, 16'd0);
    check("R1", {8'd0, led}, 16'd0);
    sr(8'h00);   // 0x07: flags clear, all coin bits high
    mr(4'd2);    // 0x0F00
    sr(8'h41);
    mr(4'd1);

    // R2 / R3 command path
    mw(4'd1, 16'hA5C3, 1'b1);
    sr(8'h00);
    sr(8'hC1);   // mirror of 0x41, R11
    sr(8'h00);

    // R9 lane-less writes
    mw(4'd1, 16'h3300, 1'b0);
    mw(4'd0, 16'h4400, 1'b0);
    mw(4'd2, 16'h5500, 1'b0);
    sr(8'h41); sr(8'h40);

    // R8 secondary bytes and lamp
    mw(4'd0, 16'h6E01, 1'b1);
    mw(4'd2, 16'h9900, 1'b1);
    sr(8'h40);
    sw(8'h40, 8'h7D);
    mr(4'd0);

    // R4 / R5 reply path and interrupt
    sw(8'h41, 8'h2B);
    mr(4'd2);
    mr(4'd1);
    mr(4'd2);
    repeat (3) @(negedge clk);
    check("R4", {15'd0, main_irq}, 16'd1);
    ack();

    // R3 set wins over simultaneous clear
    mw(4'd1, 16'h1100, 1'b1);
    m_addr = 4'd1; m_wdata = 16'h2200; m_ube = 1; m_wr = 1; s_addr = 8'h41; s_rd = 1;
    #1 check("R3", {8'd0, s_rdata}, 16'h0011);
    @(posedge clk); @(negedge clk);
    idle_inputs();
    md_cmd = 8'h22; md_cp = 1;
    check("R3", {15'd0, ctc_trg2}, 16'd1);
    sr(8'h41);

    // R4 set wins over simultaneous acknowledge
    s_addr = 8'h41; s_wdata = 8'h5C; s_wr = 1; main_irq_ack = 1;
    @(posedge clk); @(negedge clk);
    idle_inputs();
    md_rep = 8'h5C; md_rp = 1; md_irq = 1;
    check("R4", {15'd0, main_irq}, 16'd1);
    ack();
    mr(4'd1);

    // R7 / R6 coin field
    coin = 3'b101; sr(8'h00); mr(4'd2);
    coin = 3'b000; sr(8'h9E); mr(4'd2);

    // R10 / R11 unmapped
    mr(4'd3); mr(4'd15);
    sr(8'h20); sr(8'h60); sr(8'h61);

    // R12 tone chips, R13 counter trigger
    sw(8'h00, 8'h07); sw(8'h01, 8'h3F); sw(8'h20, 8'h08); sw(8'hBF, 8'h10);
    sr(8'h01); sr(8'h21);
    sw(8'hFF, 8'h00);

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom_range(0, 5);
      psg_rdata = 16'($urandom);
      case (op)
        0: mw(4'($urandom_range(0, 3)), 16'($urandom), 1'($urandom));
        1: mr(4'($urandom));
        2: sw(8'($urandom), 8'($urandom));
        3: sr(8'($urandom));
        4: ack();
        default: begin coin = 3'($urandom); sr(8'h00); end
      endcase
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

endmodule